// File: doc/BRIEF.md
# Bus Cycle Timeout Guard

This block watches the processor bus and ends any cycle that hangs. A cycle begins on the clock edge that samples `cyc_start`. It normally ends on the edge that samples `ready_in` from the addressed device. The block counts the bus clocks in between. If no device answers in time, the block raises a ready of its own for one clock so the processor can leave the stuck cycle. At the same moment it drops a sticky, active-low timeout flag and lights a timeout indicator.

Software reads the flag as a plain status bit. It clears the flag by pulsing an active-low clear control bit low and then back high. The flag returns to 1 only on that return to high.

The same block also gates an external active-low NMI request. The request is synchronised to the bus clock and then passed through a software mask bit. While the mask bit is 1, no NMI reaches the processor. The control bits arrive as plain inputs from a register held elsewhere.

Top module: `bus_cycle_watchdog`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it rises, `flag_n` is 1, `tmo_led` is 0 and `nmi_cpu_n` is 1.
- R2: Edge 0 is the edge that samples `cyc_start` high. If `ready_in` is not sampled high on any of edges 1 to LIMIT-1, `ready_out` is driven high for exactly the one clock that ends at edge LIMIT. The block is then idle. LIMIT defaults to 30.
- R3: `flag_n` falls to 0 on the same edge where the forced ready begins. A cycle whose `ready_in` is sampled on edge LIMIT-1 or earlier leaves `flag_n` at 1.
- R4: `flag_n` is sticky. It returns to 1 only after an edge that samples `clr_n` = 1 when the previous edge sampled `clr_n` = 0. Holding `clr_n` low leaves the flag at 0.
- R5: A timeout that happens while `clr_n` is held low still drives `flag_n` to 0. The flag then waits for the next low-to-high return of `clr_n`.
- R6: `tmo_led` is 1 exactly when `flag_n` is 0.
- R7: A `cyc_start` sampled during a cycle restarts the count at edge 0. While no cycle is open, `ready_in` and the passing of time never cause a timeout.
- R8: `nmi_cpu_n` is 0 only when the request `nmi_req_n`, delayed through SYNC (default 2) synchroniser stages, is 0 and `nmi_mask` is 0. The output is registered, so the total delay is SYNC+1 edges. With `nmi_mask` = 1 the output stays at 1.
- R9: `ready_out` is the OR of `ready_in` and the forced ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_start | input | 1 | Marks the first clock of a bus cycle |
| ready_in | input | 1 | Ready from the addressed device |
| ready_out | output | 1 | Ready to the processor, including the forced ready |
| clr_n | input | 1 | Active-low flag clear control bit; idles at 1 |
| flag_n | output | 1 | Sticky timeout flag; 0 means a timeout is pending |
| tmo_led | output | 1 | Timeout indicator, high while the flag is pending |
| nmi_req_n | input | 1 | External asynchronous NMI request, active low |
| nmi_mask | input | 1 | 1 blocks the NMI request |
| nmi_cpu_n | output | 1 | Gated NMI to the processor, active low |

## Verification
The bench targets the count boundary from both sides. A device that answers on edge 29 must leave the flag alone, and one that answers on edge 30 or later must get the forced ready. An off-by-one counter would flag the first case or miss the second.

It holds `clr_n` low across a timeout and for several clocks afterwards. A design that cleared on level, or that let the clear win over a fresh timeout, would show the flag at 1 too early.

A restart in mid-cycle and long idle stretches with stray ready pulses catch counters that do not reload or do not hold. Random mask and request changes expose a gate that ignores the mask or has the wrong delay.

// File: rtl/bcw_pkg.sv
// Shared types for the bus cycle watchdog.
// Assumes: nothing beyond IEEE 1800-2017.
package bcw_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_BUSY = 1'b1
    } phase_t;
endpackage

// File: rtl/bcw_cycle_timer.sv
// Counts the bus clocks of the open cycle and forces a one-clock ready
// when the device does not answer within LIMIT-1 edges of the start.
// Assumes: cyc_start and ready_in are synchronous to clk.
module bcw_cycle_timer #(
    parameter int LIMIT = 30,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic ready_in,
    output logic force_rdy,
    output logic expire
);
    import bcw_pkg::*;

    phase_t         phase_q;
    logic [CW-1:0]  cnt_q;
    logic           rdy_seen;

    // Purpose: spot the edge at which the cycle has overrun.
    always_comb begin
        rdy_seen = ready_in | force_rdy;
        expire   = (phase_q == PH_BUSY) && !rdy_seen && !cyc_start &&
                   (cnt_q == CW'(LIMIT - 1));
    end

    // Purpose: track cycle phase, elapsed clocks and the forced ready.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            force_rdy <= 1'b0;
        end else if (cyc_start) begin
            phase_q   <= PH_BUSY;
            cnt_q     <= CW'(1);
            force_rdy <= 1'b0;
        end else if (phase_q == PH_BUSY && rdy_seen) begin
            phase_q   <= PH_IDLE;
            cnt_q     <= '0;
            force_rdy <= 1'b0;
        end else if (expire) begin
            force_rdy <= 1'b1;
        end else if (phase_q == PH_BUSY) begin
            cnt_q     <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/bcw_sticky_flag.sv
// Sticky active-low timeout flag. A set always wins. A clear happens
// only when the clear bit goes from 0 to 1.
// Assumes: clr_n comes from an on-chip register clocked by clk.
module bcw_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_n,
    output logic flag_n
);
    logic clr_q;
    logic clr_rise;

    // Purpose: detect the low-to-high return of the clear bit.
    always_comb clr_rise = clr_n & ~clr_q;

    // Purpose: hold the flag and the previous clear bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clr_q  <= 1'b1;
            flag_n <= 1'b1;
        end else begin
            clr_q <= clr_n;
            if (set_i)
                flag_n <= 1'b0;
            else if (clr_rise)
                flag_n <= 1'b1;
        end
    end
endmodule

// File: rtl/bcw_nmi_gate.sv
// Synchronises the external NMI request and blocks it while masked.
// Assumes: nmi_req_n is asynchronous and nmi_mask is synchronous.
module bcw_nmi_gate #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req_n,
    input  logic nmi_mask,
    output logic nmi_cpu_n
);
    logic [SYNC-1:0] sync_q;

    for (genvar g = 0; g < SYNC; g++) begin : g_stage
        if (g == 0) begin : g_first
            // Purpose: first capture of the asynchronous request.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b1;
                else        sync_q[0] <= nmi_req_n;
            end
        end else begin : g_next
            // Purpose: further settling stage.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b1;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Purpose: registered mask gate; the output idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_cpu_n <= 1'b1;
        else        nmi_cpu_n <= sync_q[SYNC-1] | nmi_mask;
    end
endmodule

// File: rtl/bus_cycle_watchdog.sv
// Top of the bus cycle watchdog: the cycle timer, the sticky flag and
// the NMI gate.
// Assumes: all control bits come from registers in the clk domain,
// except nmi_req_n.
module bus_cycle_watchdog #(
    parameter int LIMIT = 30,
    parameter int SYNC  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic ready_in,
    output logic ready_out,
    input  logic clr_n,
    output logic flag_n,
    output logic tmo_led,
    input  logic nmi_req_n,
    input  logic nmi_mask,
    output logic nmi_cpu_n
);
    logic force_rdy;
    logic expire;

    bcw_cycle_timer #(.LIMIT(LIMIT)) u_timer (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start),
        .ready_in(ready_in), .force_rdy(force_rdy), .expire(expire)
    );

    bcw_sticky_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(expire),
        .clr_n(clr_n), .flag_n(flag_n)
    );

    bcw_nmi_gate #(.SYNC(SYNC)) u_nmi (
        .clk(clk), .rst_n(rst_n), .nmi_req_n(nmi_req_n),
        .nmi_mask(nmi_mask), .nmi_cpu_n(nmi_cpu_n)
    );

    // Purpose: merge the device ready with the forced ready and drive the indicator.
    always_comb begin
        ready_out = ready_in | force_rdy;
        tmo_led   = ~flag_n;
    end
endmodule

// File: rtl/bcw_checker.sv
// Temporal checks on the watchdog, bound into the top module.
// Assumes: synchronous active-low reset on rst_n.
module bcw_checker (
    input logic clk,
    input logic rst_n,
    input logic clr_n,
    input logic flag_n,
    input logic force_rdy,
    input logic nmi_mask,
    input logic nmi_cpu_n
);
    // R2: the forced ready lasts a single clock
    a_r2_force_single: assert property (@(posedge clk) disable iff (!rst_n)
        force_rdy |=> !force_rdy);

    // R3: the flag only falls together with the start of a forced ready
    a_r3_fall_with_force: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_n) |-> $rose(force_rdy));

    // R4: the flag only rises after the clear bit went from 0 to 1
    a_r4_rise_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_n) |-> ($past(clr_n) && !$past(clr_n, 2)));

    // R8: no NMI gets through while the mask was set
    a_r8_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        !nmi_cpu_n |-> !$past(nmi_mask));
endmodule

bind bus_cycle_watchdog bcw_checker u_chk (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .flag_n(flag_n),
    .force_rdy(force_rdy), .nmi_mask(nmi_mask), .nmi_cpu_n(nmi_cpu_n)
);

// File: tb/sim_bus_cycle_watchdog.sv
module sim_bus_cycle_watchdog;
    localparam int LIMIT = 30;
    localparam int SYNC  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, rdy = 1'b0, clr = 1'b1, nreq = 1'b1, mask = 1'b1;
    logic ready_out, flag_n, tmo_led, nmi_cpu_n;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    bus_cycle_watchdog #(.LIMIT(LIMIT), .SYNC(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_start(cs), .ready_in(rdy),
        .ready_out(ready_out), .clr_n(clr), .flag_n(flag_n),
        .tmo_led(tmo_led), .nmi_req_n(nreq), .nmi_mask(mask),
        .nmi_cpu_n(nmi_cpu_n)
    );

    // Reference state, stepped from the requirements
    bit m_busy, m_force, m_flag, m_clrq, m_out;
    int m_cnt;
    bit m_sync [SYNC];

    always @(posedge clk) begin
        bit seen, exp_set;
        if (!rst_n) begin
            m_busy = 0; m_force = 0; m_cnt = 0; m_flag = 1; m_clrq = 1; m_out = 1;
            foreach (m_sync[i]) m_sync[i] = 1;
        end else begin
            seen    = rdy | m_force;
            exp_set = m_busy && !seen && !cs && (m_cnt == LIMIT - 1);
            m_out   = m_sync[SYNC-1] | mask;
            for (int i = SYNC - 1; i > 0; i--) m_sync[i] = m_sync[i-1];
            m_sync[0] = nreq;
            if (exp_set) m_flag = 0;
            else if (clr && !m_clrq) m_flag = 1;
            m_clrq = clr;
            if (cs) begin m_busy = 1; m_cnt = 1; m_force = 0; end
            else if (m_busy && seen) begin m_busy = 0; m_cnt = 0; m_force = 0; end
            else if (exp_set) m_force = 1;
            else if (m_busy) m_cnt++;
        end
    end

    function automatic bit exp_ready();
        return rdy | m_force;                       // R9
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        chk("R2/R9 ready_out", ready_out, exp_ready());
        chk("R3/R4 flag_n", flag_n, m_flag);
        chk("R6 tmo_led", tmo_led, !m_flag);
        chk("R8 nmi_cpu_n", nmi_cpu_n, m_out);
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic bus_cycle(int lat);
        cs = 1; tick(); cs = 0;
        repeat (lat - 1) tick();
        rdy = 1; tick(); rdy = 0;
    endtask

    // Watchdog: an expired run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            chk("R1 flag_n in reset", flag_n, 1'b1);
            chk("R1 tmo_led in reset", tmo_led, 1'b0);
            chk("R1 nmi_cpu_n in reset", nmi_cpu_n, 1'b1);
        end
        rst_n = 1;
        tick();
        chk("R1 flag_n after reset", flag_n, 1'b1);

        // R3: an answer on edge LIMIT-1 is in time
        bus_cycle(LIMIT - 1);
        repeat (3) tick();
        chk("R3 no flag at LIMIT-1", flag_n, 1'b1);

        // R2: an answer on edge LIMIT is too late; forced ready in the last clock
        cs = 1; tick(); cs = 0;
        repeat (LIMIT - 2) tick();
        chk("R2 no ready before LIMIT", ready_out, 1'b0);
        tick();
        chk("R2 forced ready", ready_out, 1'b1);
        chk("R3 flag falls with forced ready", flag_n, 1'b0);
        chk("R6 led on", tmo_led, 1'b1);
        tick();
        chk("R2 forced ready one clock", ready_out, 1'b0);

        // R4: holding clear low does not clear; the return to 1 does
        clr = 0; repeat (4) tick();
        chk("R4 held low keeps flag", flag_n, 1'b0);
        clr = 1; tick();
        chk("R4 rise clears flag", flag_n, 1'b1);

        // R5: timeout while clear is held low
        clr = 0; tick();
        bus_cycle(LIMIT + 5);
        repeat (2) tick();
        chk("R5 set while clear low", flag_n, 1'b0);
        clr = 1; tick();
        chk("R5 cleared by later rise", flag_n, 1'b1);

        // R7: restart in mid-cycle, then a long idle stretch with stray readies
        cs = 1; tick(); cs = 0;
        repeat (20) tick();
        bus_cycle(20);
        chk("R7 restart reloads count", flag_n, 1'b1);
        for (int i = 0; i < 3 * LIMIT; i++) begin
            rdy = (i % 17 == 0); tick();
        end
        rdy = 0; tick();
        chk("R7 idle never times out", flag_n, 1'b1);

        // R8: mask gating
        nreq = 0; mask = 1; repeat (SYNC + 3) tick();
        chk("R8 masked request blocked", nmi_cpu_n, 1'b1);
        mask = 0; repeat (SYNC + 3) tick();
        chk("R8 unmasked request passes", nmi_cpu_n, 1'b0);
        nreq = 1; repeat (SYNC + 3) tick();
        chk("R8 released request", nmi_cpu_n, 1'b1);

        // Random traffic checked against the reference every clock
        for (int i = 0; i < 6000; i++) begin
            cs   = ($urandom % 12) == 0;
            rdy  = ($urandom % 45) == 0;
            if (($urandom % 40) == 0) clr  = ~clr;
            if (($urandom % 15) == 0) nreq = ~nreq;
            if (($urandom % 25) == 0) mask = ~mask;
            tick();
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule